// File: doc/BRIEF.md
# Page-Mode ROM Read Controller

This block sits between a synchronous host and an external asynchronous mask ROM that supports a fast page read. The host asks for one byte or one 16-bit word at a time. The controller drives the ROM address, chip enable, output enable and the width select. It waits a fixed number of clock cycles, captures the ROM data and returns it to the host as a single response pulse.

The ROM returns data faster when consecutive reads stay inside one aligned 16-byte page and chip enable stays asserted. The controller records which page is open and in which width mode. A read that lands in the open page, in the same mode, uses the short page wait. Any other read uses the full random-access wait.

Every access time is a nanosecond parameter. Each one is rounded up to whole cycles of a clock-period parameter. If the host sends no request for a parameterised number of cycles, the controller puts the device into standby and forgets the open page. In byte mode the top ROM data pin acts as the lowest address bit. Only the low data byte is meaningful in that mode, so the upper half of the response is zero.

Top module: `prom_rd_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no request yet issued, `rom_ce_n` and `rom_oe_n` are 1, `req_ready` is 1, `rsp_valid` is 0 and `rom_word_mode` is 1.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the cycle in which `rsp_valid` is 1, and `req_ready` is 1 in that cycle.
- R3: A read that is not a page hit has its `rsp_valid` in the cycle that follows the Nr-th rising edge after the accepting edge. Nr is the larger of ceil(T_RAND_NS/CLK_PERIOD_NS) and ceil(T_OE_NS/CLK_PERIOD_NS), which is 20 with the defaults.
- R4: A page hit uses Np = ceil(T_PAGE_NS/CLK_PERIOD_NS) edges instead, which is 6 with the defaults. A page hit means all of the following: a previous read is open, `req_addr[21:4]` equals that read's bits, `req_byte` equals that read's mode, and chip enable has stayed low since that read.
- R5: While a read is outstanding and up to its response, `rom_addr` equals `req_addr[21:1]` and `rom_word_mode` equals `!req_byte`. `rom_a_m1` equals `req_addr[0]` in byte mode and 0 in word mode.
- R6: In word mode `rsp_data` is the `rom_q` value captured on the final wait edge. In byte mode it is `{8'h00, rom_q[7:0]}`, and `rom_q[15:8]` is ignored.
- R7: From the cycle after acceptance up to and including the response cycle, `rom_ce_n` and `rom_oe_n` are 0 and `rom_addr` does not change.
- R8: A change of `req_byte` from the previous read forces the full random-access wait, even when the page bits match.
- R9: After a response, suppose IDLE_CYC rising edges (16 with the defaults) pass in the ready state with no acceptance. Then `rom_ce_n` and `rom_oe_n` go to 1, and the next read takes the random-access wait. A request taken on the IDLE_CYC-th such edge is still a page hit.
- R10: `rsp_valid` is a single-cycle pulse, given exactly once for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Host read request |
| req_addr | input | 22 | Byte address of the read |
| req_byte | input | 1 | 1 selects byte mode, 0 selects word mode |
| req_ready | output | 1 | Controller can take a request |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_data | output | 16 | Read data, upper byte zero in byte mode |
| rom_addr | output | 21 | ROM word address lines |
| rom_a_m1 | output | 1 | Lowest byte address bit, driven onto the top data pin in byte mode |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_word_mode | output | 1 | 1 selects 16-bit word mode, 0 selects byte mode |
| rom_q | input | 16 | ROM data outputs |

## Verification
Each response is due a fixed number of cycles after its accepting edge: 20 edges for a random read and 6 for a page hit. The driver counts edges on a free-running cycle counter. It stores the exact due cycle and the expected data in a queue, and the monitor compares the cycle of each `rsp_valid` pulse and its data against the head of that queue. The idle gap before each request is controlled to the edge. This places reads exactly on both sides of the timeout boundary. The state of chip enable is checked at the ports just before each read that follows a gap.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } rd_state_e;

  // Round a time in ns up to whole clock cycles, never less than one.
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                            input int unsigned period_ns);
    int unsigned c;
    c = (t_ns + period_ns - 1) / period_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prom_cyc_timer.sv
module prom_cyc_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/prom_page_track.sv
module prom_page_track #(
  parameter int unsigned TAG_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  input  logic             look_byte,
  input  logic             update,
  input  logic             clear,
  output logic             hit
);

  logic             vld_q, vld_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             byte_q, byte_d;

  always_comb begin
    vld_d  = vld_q;
    tag_d  = tag_q;
    byte_d = byte_q;
    if (update) begin
      vld_d  = 1'b1;
      tag_d  = look_tag;
      byte_d = look_byte;
    end else if (clear) begin
      vld_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      tag_q  <= '0;
      byte_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      tag_q  <= tag_d;
      byte_q <= byte_d;
    end
  end

  assign hit = vld_q && (tag_q == look_tag) && (byte_q == look_byte);

endmodule

// File: rtl/prom_idle_mon.sv
module prom_idle_mon #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic restart,
  output logic expire
);

  localparam int unsigned IW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [IW-1:0] LAST = IW'(LIMIT - 1);

  logic [IW-1:0] cnt_q, cnt_d;

  assign expire = arm && !restart && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !arm || expire) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/prom_rd_ctrl.sv
module prom_rd_ctrl
  import prom_rd_pkg::*;
#(
  parameter int unsigned ADDR_W        = 22,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned PAGE_LSB      = 4,
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned T_RAND_NS     = 100,
  parameter int unsigned T_PAGE_NS     = 30,
  parameter int unsigned T_OE_NS       = 30,
  parameter int unsigned IDLE_CYC      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_byte,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-2:0] rom_addr,
  output logic              rom_a_m1,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic              rom_word_mode,
  input  logic [DATA_W-1:0] rom_q
);

  localparam int unsigned RAND_CYC = max_u(ns_to_cyc(T_RAND_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(T_OE_NS, CLK_PERIOD_NS));
  localparam int unsigned PAGE_CYC = ns_to_cyc(T_PAGE_NS, CLK_PERIOD_NS);
  localparam int unsigned CNT_W    = $clog2(RAND_CYC + 1);
  localparam int unsigned TAG_W    = ADDR_W - PAGE_LSB;
  localparam int unsigned BYTE_W   = DATA_W / 2;
  localparam logic [CNT_W-1:0] RAND_LD = CNT_W'(RAND_CYC - 1);
  localparam logic [CNT_W-1:0] PAGE_LD = CNT_W'(PAGE_CYC - 1);

  rd_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              byte_q, byte_d;
  logic              ce_n_q, ce_n_d;
  logic              oe_n_q, oe_n_d;
  logic              rsp_v_q, rsp_v_d;
  logic [DATA_W-1:0] rsp_q, rsp_d;

  logic              accept;
  logic              tag_hit;
  logic              page_hit;
  logic              wait_done;
  logic              idle_expire;
  logic              finish;
  logic [DATA_W-1:0] cap_data;

  assign accept   = req_valid && (state_q == ST_IDLE);
  assign page_hit = tag_hit && !ce_n_q;
  assign finish   = (state_q == ST_WAIT) && wait_done;

  prom_page_track #(
    .TAG_W (TAG_W)
  ) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_tag  (req_addr[ADDR_W-1:PAGE_LSB]),
    .look_byte (req_byte),
    .update    (accept && !page_hit),
    .clear     (idle_expire),
    .hit       (tag_hit)
  );

  prom_cyc_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (page_hit ? PAGE_LD : RAND_LD),
    .run      (state_q == ST_WAIT),
    .expired  (wait_done)
  );

  prom_idle_mon #(
    .LIMIT (IDLE_CYC)
  ) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     ((state_q == ST_IDLE) && !ce_n_q),
    .restart (accept),
    .expire  (idle_expire)
  );

  // Byte mode keeps only the low data lane; the upper lane is zero-filled.
  generate
    if (DATA_W > BYTE_W) begin : g_lane
      assign cap_data = byte_q ? {{(DATA_W-BYTE_W){1'b0}}, rom_q[BYTE_W-1:0]} : rom_q;
    end else begin : g_flat
      assign cap_data = rom_q;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    byte_d  = byte_q;
    ce_n_d  = ce_n_q;
    oe_n_d  = oe_n_q;
    rsp_v_d = 1'b0;
    rsp_d   = rsp_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_WAIT;
          addr_d  = req_addr;
          byte_d  = req_byte;
          ce_n_d  = 1'b0;
          oe_n_d  = 1'b0;
        end else if (idle_expire) begin
          ce_n_d  = 1'b1;
          oe_n_d  = 1'b1;
        end
      end
      ST_WAIT: begin
        if (finish) begin
          state_d = ST_IDLE;
          rsp_v_d = 1'b1;
          rsp_d   = cap_data;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      byte_q  <= 1'b0;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      rsp_v_q <= 1'b0;
      rsp_q   <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      byte_q  <= byte_d;
      ce_n_q  <= ce_n_d;
      oe_n_q  <= oe_n_d;
      rsp_v_q <= rsp_v_d;
      rsp_q   <= rsp_d;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = rsp_v_q;
  assign rsp_data      = rsp_q;
  assign rom_addr      = addr_q[ADDR_W-1:1];
  assign rom_a_m1      = byte_q && addr_q[0];
  assign rom_ce_n      = ce_n_q;
  assign rom_oe_n      = oe_n_q;
  assign rom_word_mode = !byte_q;

endmodule

// File: rtl/prom_rd_ctrl_chk.sv
module prom_rd_ctrl_chk #(
  parameter int unsigned AW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] rom_addr,
  input logic          rom_a_m1,
  input logic          rom_ce_n,
  input logic          rom_oe_n,
  input logic          rom_word_mode
);

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_ready_at_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  p_enables_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (!rom_ce_n && !rom_oe_n));

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(rom_addr));

  p_addr_at_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $stable(rom_addr));

  p_word_am1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rom_word_mode |-> !rom_a_m1);

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_after_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!req_ready));

  p_standby_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rom_ce_n |-> rom_oe_n);

endmodule

bind prom_rd_ctrl prom_rd_ctrl_chk #(.AW(ADDR_W-1)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rom_addr      (rom_addr),
  .rom_a_m1      (rom_a_m1),
  .rom_ce_n      (rom_ce_n),
  .rom_oe_n      (rom_oe_n),
  .rom_word_mode (rom_word_mode)
);

// File: tb/prom_rd_ctrl_tb.sv
module prom_rd_ctrl_tb;

  localparam int unsigned NR   = 20;  // R3: ceil(100/5)
  localparam int unsigned NP   = 6;   // R4: ceil(30/5)
  localparam int unsigned IDLE = 16;  // R9

  logic        clk, rst_n;
  logic        req_valid, req_byte, req_ready, rsp_valid;
  logic [21:0] req_addr;
  logic [15:0] rsp_data, rom_q, rom_w;
  logic [20:0] rom_addr;
  logic        rom_a_m1, rom_ce_n, rom_oe_n, rom_word_mode;

  int unsigned cyc = 0;
  int unsigned last_rsp = 0;
  int n_chk = 0, n_fail = 0;

  typedef struct {
    logic [15:0] data;
    int unsigned due;
    logic [20:0] addr;
    logic        am1;
    string       tag;
  } sb_t;
  sb_t sb_q[$];

  bit          pv = 0;
  logic [17:0] pg = '0;
  logic        md = 1'b0;
  bit          wait_bad = 0;
  bit          prev_rsp = 0;

  prom_rd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_byte(req_byte), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rom_addr(rom_addr), .rom_a_m1(rom_a_m1),
    .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_word_mode(rom_word_mode),
    .rom_q(rom_q)
  );

  function automatic logic [15:0] rom_f(input logic [20:0] a);
    return (a[15:0] * 16'd37) ^ {a[20:16], 11'h2A5};
  endfunction

  assign rom_w = rom_f(rom_addr);
  assign rom_q = rom_word_mode ? rom_w : {8'hC3, rom_a_m1 ? rom_w[15:8] : rom_w[7:0]};

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (!req_ready && sb_q.size() != 0) begin
        if (rom_ce_n || rom_oe_n || rom_addr != sb_q[0].addr) wait_bad = 1;
      end
      if (rsp_valid) begin
        chk(!prev_rsp && sb_q.size() != 0, "R10", "single pulse per request",
            {31'd0, prev_rsp}, 32'd0);
        if (sb_q.size() != 0) begin
          sb_t it;
          it = sb_q.pop_front();
          chk(cyc == it.due, it.tag, "response cycle", cyc, it.due);
          chk(rsp_data == it.data, "R6", "response data", {16'd0, rsp_data}, {16'd0, it.data});
          chk(rom_addr == it.addr && rom_a_m1 == it.am1, "R5", "ROM address",
              {10'd0, rom_addr, rom_a_m1}, {10'd0, it.addr, it.am1});
          chk(!wait_bad && !rom_ce_n && !rom_oe_n, "R7", "enables/address during wait",
              {31'd0, wait_bad}, 32'd0);
          chk(req_ready, "R2", "ready in response cycle", {31'd0, req_ready}, 32'd1);
        end
        wait_bad = 0;
        last_rsp = cyc;
      end
      prev_rsp = rsp_valid;
    end
  end

  task automatic do_read(input logic [21:0] a, input logic bm, input int unsigned gap);
    int unsigned k, g, n;
    bit hit;
    sb_t it;
    logic [15:0] w;
    while (sb_q.size() != 0) @(posedge clk);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    while (cyc + 1 < last_rsp + gap) @(negedge clk);
    k = cyc;
    g = k + 1 - last_rsp;
    if (pv && g > IDLE)
      chk(rom_ce_n && rom_oe_n, "R9", "standby after idle timeout",
          {30'd0, rom_ce_n, rom_oe_n}, 32'd3);
    else if (pv)
      chk(!rom_ce_n && !rom_oe_n, "R9", "enables held before timeout",
          {30'd0, rom_ce_n, rom_oe_n}, 32'd0);
    hit = pv && (md == bm) && (pg == a[21:4]) && (g <= IDLE);
    n = hit ? NP : NR;
    w = rom_f(a[21:1]);
    it.data = bm ? {8'h00, a[0] ? w[15:8] : w[7:0]} : w;
    it.due  = k + 1 + n;
    it.addr = a[21:1];
    it.am1  = bm & a[0];
    if (hit)                               it.tag = "R4";
    else if (pv && md != bm && pg == a[21:4]) it.tag = "R8";
    else if (pv && g > IDLE)               it.tag = "R9";
    else                                   it.tag = "R3";
    sb_q.push_back(it);
    pv = 1; pg = a[21:4]; md = bm;
    req_addr  = a;
    req_byte  = bm;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2", "ready low after accept", {31'd0, req_ready}, 32'd0);
    chk(rom_word_mode == !bm, "R5", "width select", {31'd0, rom_word_mode}, {31'd0, !bm});
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_byte = 1'b0;
    req_addr = '0;
    repeat (3) @(negedge clk);
    chk(rom_ce_n && rom_oe_n && req_ready && !rsp_valid && rom_word_mode, "R1",
        "state in reset", {27'd0, rom_ce_n, rom_oe_n, req_ready, rsp_valid, rom_word_mode}, 32'h1D);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rom_ce_n && rom_oe_n && req_ready && !rsp_valid && rom_word_mode, "R1",
        "state after reset", {27'd0, rom_ce_n, rom_oe_n, req_ready, rsp_valid, rom_word_mode}, 32'h1D);

    do_read(22'h000100, 1'b0, 1);          // R3 first read
    do_read(22'h00010A, 1'b0, 2);          // R4 hit
    do_read(22'h00010E, 1'b0, 5);          // R4 hit
    do_read(22'h000200, 1'b0, 3);          // R3 new page
    do_read(22'h000201, 1'b1, 2);          // R8 mode change, same page
    do_read(22'h00020F, 1'b1, 2);          // R4 hit, byte, a_m1 = 1
    do_read(22'h000204, 1'b1, IDLE);       // R9 boundary, still hit
    do_read(22'h000206, 1'b1, IDLE + 1);   // R9 timed out
    do_read(22'h3FFFFE, 1'b0, 2);          // R3 top of range
    do_read(22'h3FFFF0, 1'b0, 2);          // R4 hit
    do_read(22'h3FFFF3, 1'b0, IDLE + 8);   // R9 long gap
    do_read(22'h3FFFF7, 1'b1, 2);          // R8 mode change
    while (sb_q.size() != 0) @(posedge clk);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule